// File: doc/BRIEF.md
# IrDA SIR Pulse Codec

This block sits between a UART and an infrared transceiver. On the transmit side it takes the UART's serial stream (NRZ) and sends one short high pulse on the infrared output for every zero bit. A one bit, or an idle mark line, leaves the infrared output low. On the receive side it watches the infrared input for pulses and rebuilds an NRZ stream for a UART receiver. A pulse produces a low bit on the NRZ output. With no pulses the NRZ output stays high.

All timing counts in slots. A slot is one period of a single-cycle enable that runs at 16 times the baud rate, so one bit lasts 16 slots by default. An invert control flips the sense of the received line, for transceivers that signal a pulse with a low level. A mode input switches the codec out of the path. Both directions are single-bit serial lines with no back-pressure: the codec must accept and produce one bit per bit time. For that reason no valid/ready handshake is used; the lines and controls are plain wires.

Top module: `ir_sir_codec`

## Requirements
- R1: With the codec enabled, a zero bit on `tx_nrz_i` drives `tx_ir_o` high for exactly the first 3 slots of that bit. `tx_ir_o` changes one clock after the `tick16` cycle that begins each slot.
- R2: With the codec enabled, a one bit keeps `tx_ir_o` low for the whole bit.
- R3: With the codec enabled and `tx_nrz_i` idling high, `tx_ir_o` stays low, including right after reset.
- R4: The transmit slot count restarts at slot 0 on the first tick after any change of `tx_nrz_i`. Otherwise it wraps every 16 slots, so every zero bit in a run of zeros gets its own pulse.
- R5: The received line passes through a two-flop synchronizer that resets to 0, so after reset `rx_nrz_o` is high (mark).
- R6: A rising edge of the received level (`rx_ir_i` XOR `rx_invert`) drives `rx_nrz_o` low from the next tick for 16 slots. After that it returns high.
- R7: A new pulse that arrives while the output is held low restarts the 16-slot hold.
- R8: With `rx_invert` = 1, a low-going pulse on an input that idles high is decoded as a zero bit. The steady high idle level produces no zero bits.
- R9: With `ir_en` = 0, `tx_ir_o` follows `tx_nrz_i` and `rx_nrz_o` follows `rx_ir_i` combinationally. While disabled, the encoder and decoder state are held cleared.
- R10: Decoding is edge-based. An input held high for longer than a bit gives only one 16-slot low, and the falling edge that ends it gives none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x baud rate, marks each slot |
| ir_en | input | 1 | 1 = encode/decode, 0 = pass NRZ straight through |
| rx_invert | input | 1 | 1 = received pulses are active-low |
| tx_nrz_i | input | 1 | Serial NRZ data from the UART transmitter |
| tx_ir_o | output | 1 | Pulse stream to the infrared emitter |
| rx_ir_i | input | 1 | Pulse stream from the infrared detector |
| rx_nrz_o | output | 1 | Rebuilt NRZ data for the UART receiver |

## Verification
Transmit is driven with an alternating and clustered bit pattern. This separates zero bits, which must give a three-slot pulse (the samples in slots 1, 2 and 3 bound its length), from one bits, which must stay dark, and it shows that back-to-back zeros each get a pulse. A transition placed mid-period shows that the slot count realigns to data edges rather than to a free-running phase. On receive, a single pulse, two overlapping pulses, a long high level and an inverted-polarity pulse tell apart the fixed hold, the restart of the hold, edge versus level detection, and the polarity control. Bypass toggles both lines to show that the coder is removed from the path.

// File: rtl/ir_sir_pkg.sv
package ir_sir_pkg;
  localparam int unsigned SLOTS_PER_BIT_DEF = 16;
  localparam int unsigned PULSE_SLOTS_DEF   = 3;
  localparam int unsigned HOLD_SLOTS_DEF    = 16;
  localparam int unsigned SYNC_STAGES_DEF   = 2;
endpackage

// File: rtl/ir_sir_tx_enc.sv
module ir_sir_tx_enc #(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned PULSE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic nrz_i,
  output logic ir_o
);
  localparam int unsigned PW = $clog2(SLOTS);
  localparam logic [PW-1:0] LAST_SLOT = PW'(SLOTS - 1);
  localparam logic [PW-1:0] PULSE_END = PW'(PULSE);

  logic [PW-1:0] next_slot_q;
  logic [PW-1:0] slot;
  logic          last_q;
  logic          pulse_q;
  logic          data_edge;

  // a data transition realigns the bit period to slot 0
  assign data_edge = (nrz_i != last_q);
  assign slot      = data_edge ? '0 : next_slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_slot_q <= '0;
      last_q      <= 1'b1;
      pulse_q     <= 1'b0;
    end else if (clr) begin
      next_slot_q <= '0;
      last_q      <= 1'b1;
      pulse_q     <= 1'b0;
    end else if (tick) begin
      last_q      <= nrz_i;
      next_slot_q <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
      pulse_q     <= !nrz_i && (slot < PULSE_END);
    end
  end

  assign ir_o = pulse_q;
endmodule

// File: rtl/ir_sir_rx_front.sv
module ir_sir_rx_front #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  input  logic invert,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              level;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= rx_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign level = sync_q[STAGES-1] ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise_o = level & ~prev_q;
endmodule

// File: rtl/ir_sir_rx_dec.sv
module ir_sir_rx_dec #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic rise_i,
  output logic nrz_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD);

  logic [CW-1:0] left_q;
  logic          armed_q;
  logic          go;

  assign go = armed_q | rise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      armed_q <= 1'b0;
    end else if (clr) begin
      left_q  <= '0;
      armed_q <= 1'b0;
    end else if (tick) begin
      armed_q <= 1'b0;
      if (go)                left_q <= HOLD_LOAD;
      else if (left_q != '0) left_q <= left_q - 1'b1;
    end else if (rise_i) begin
      armed_q <= 1'b1;
    end
  end

  assign nrz_o = (left_q == '0);
endmodule

// File: rtl/ir_sir_codec.sv
module ir_sir_codec
  import ir_sir_pkg::*;
#(
  parameter int unsigned SLOTS_PER_BIT = SLOTS_PER_BIT_DEF,
  parameter int unsigned PULSE_SLOTS   = PULSE_SLOTS_DEF,
  parameter int unsigned HOLD_SLOTS    = HOLD_SLOTS_DEF,
  parameter int unsigned SYNC_STAGES   = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic ir_en,
  input  logic rx_invert,
  input  logic tx_nrz_i,
  output logic tx_ir_o,
  input  logic rx_ir_i,
  output logic rx_nrz_o
);
  logic enc_ir;
  logic rx_rise;
  logic dec_nrz;
  logic coder_off;

  assign coder_off = ~ir_en;

  ir_sir_tx_enc #(
    .SLOTS (SLOTS_PER_BIT),
    .PULSE (PULSE_SLOTS)
  ) u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (coder_off),
    .tick  (tick16),
    .nrz_i (tx_nrz_i),
    .ir_o  (enc_ir)
  );

  ir_sir_rx_front #(
    .STAGES (SYNC_STAGES)
  ) u_front (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_ir_i),
    .invert (rx_invert),
    .rise_o (rx_rise)
  );

  ir_sir_rx_dec #(
    .HOLD (HOLD_SLOTS)
  ) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (coder_off),
    .tick   (tick16),
    .rise_i (rx_rise),
    .nrz_o  (dec_nrz)
  );

  assign tx_ir_o  = ir_en ? enc_ir  : tx_nrz_i;
  assign rx_nrz_o = ir_en ? dec_nrz : rx_ir_i;
endmodule

// File: rtl/ir_sir_codec_chk.sv
module ir_sir_codec_chk #(
  parameter int unsigned SLOTS_PER_BIT = 16,
  parameter int unsigned PULSE_SLOTS   = 3
) (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic ir_en,
  input logic tx_nrz_i,
  input logic tx_ir_o,
  input logic rx_nrz_o
);
  localparam int unsigned CW = $clog2(SLOTS_PER_BIT + 1);
  localparam logic [CW-1:0] PULSE_MAX = CW'(PULSE_SLOTS);

  logic [CW-1:0] hi_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hi_ticks <= '0;
    else if (!ir_en || !tx_ir_o)  hi_ticks <= '0;
    else if (tick16 && hi_ticks != '1) hi_ticks <= hi_ticks + 1'b1;
  end

  // R1: a transmit pulse never spans more slots than allowed
  a_r1_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ticks <= PULSE_MAX);

  // R1: encoded output moves only after a slot tick
  a_r1_tx_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && $past(ir_en) && !$past(tick16)) |-> $stable(tx_ir_o));

  // R2/R3: a mark sampled at a tick leaves the emitter dark
  a_r3_mark_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && $past(ir_en) && $past(tick16) && $past(tx_nrz_i)) |-> !tx_ir_o);

  // R6: decoded low starts only on a slot tick
  a_r6_low_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && $past(ir_en) && $fell(rx_nrz_o)) |-> $past(tick16));

  // R10: decoded release happens only on a slot tick
  a_r10_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && $past(ir_en) && $rose(rx_nrz_o)) |-> $past(tick16));
endmodule

bind ir_sir_codec ir_sir_codec_chk #(
  .SLOTS_PER_BIT (SLOTS_PER_BIT),
  .PULSE_SLOTS   (PULSE_SLOTS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick16   (tick16),
  .ir_en    (ir_en),
  .tx_nrz_i (tx_nrz_i),
  .tx_ir_o  (tx_ir_o),
  .rx_nrz_o (rx_nrz_o)
);

// File: tb/ir_sir_codec_tb.sv
module ir_sir_codec_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_en = 1'b1;
  logic rx_invert = 1'b0;
  logic tx_nrz = 1'b1;
  logic rx_ir = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic tick16;
  logic tx_ir;
  logic rx_nrz;
  int checks = 0;
  int errors = 0;

  // {data bit, expected level during pulse slots}
  localparam logic [1:0] TXV [0:9] = '{2'b01, 2'b10, 2'b01, 2'b10, 2'b01,
                                       2'b01, 2'b10, 2'b10, 2'b01, 2'b10};

  always #2.5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd3);

  ir_sir_codec u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .ir_en     (ir_en),
    .rx_invert (rx_invert),
    .tx_nrz_i  (tx_nrz),
    .tx_ir_o   (tx_ir),
    .rx_ir_i   (rx_ir),
    .rx_nrz_o  (rx_nrz)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // stop at the falling edge just before the next tick cycle
  task automatic adv();
    @(posedge clk);
    do @(negedge clk); while (!tick16);
  endtask

  task automatic advn(input int n);
    for (int i = 0; i < n; i++) adv();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R5 rx idle mark after reset", rx_nrz, 1'b1);
    chk("R3 tx dark after reset", tx_ir, 1'b0);
    adv();
    chk("R3 tx dark on idle mark", tx_ir, 1'b0);

    // transmit vector table
    for (int v = 0; v < 10; v++) begin
      tx_nrz = TXV[v][1];
      for (int k = 1; k <= 16; k++) begin
        adv();
        if (k == 2 || k == 3)
          chk(TXV[v][1] ? "R2 one bit dark" : "R1 zero bit pulse", tx_ir, TXV[v][0]);
        if (k == 4) chk("R1 pulse ends after 3 slots", tx_ir, 1'b0);
        if (k == 9) chk("R2 mid-bit dark", tx_ir, 1'b0);
      end
    end

    // R4: transition mid-period realigns slots, runs of zeros repeat pulses
    advn(5);
    tx_nrz = 1'b0;
    for (int k = 1; k <= 20; k++) begin
      adv();
      if (k == 2)  chk("R4 realigned pulse", tx_ir, 1'b1);
      if (k == 4)  chk("R4 realigned pulse end", tx_ir, 1'b0);
      if (k == 18) chk("R4 second zero pulse", tx_ir, 1'b1);
      if (k == 20) chk("R4 second zero pulse end", tx_ir, 1'b0);
    end
    tx_nrz = 1'b1;
    advn(16);

    // R6: single pulse
    rx_ir = 1'b1; advn(3); rx_ir = 1'b0;
    advn(5);  chk("R6 decoded low", rx_nrz, 1'b0);
    advn(14); chk("R6 released after hold", rx_nrz, 1'b1);

    // R7: second pulse restarts hold
    adv();
    rx_ir = 1'b1; advn(3); rx_ir = 1'b0;
    advn(9);
    rx_ir = 1'b1; advn(3); rx_ir = 1'b0;
    advn(5);  chk("R7 hold extended", rx_nrz, 1'b0);
    advn(6);  chk("R7 hold still extended", rx_nrz, 1'b0);
    advn(8);  chk("R7 released", rx_nrz, 1'b1);

    // R10: long high level decodes once
    adv();
    rx_ir = 1'b1;
    advn(8);  chk("R10 long level low", rx_nrz, 1'b0);
    advn(16); chk("R10 level does not retrigger", rx_nrz, 1'b1);
    rx_ir = 1'b0;
    advn(20); chk("R10 falling edge ignored", rx_nrz, 1'b1);

    // R8: inverted polarity
    ir_en = 1'b0; rx_ir = 1'b1; rx_invert = 1'b1;
    advn(2);
    ir_en = 1'b1;
    advn(20); chk("R8 high idle ignored", rx_nrz, 1'b1);
    rx_ir = 1'b0; advn(3); rx_ir = 1'b1;
    advn(5);  chk("R8 low pulse decoded", rx_nrz, 1'b0);
    advn(14); chk("R8 released", rx_nrz, 1'b1);
    ir_en = 1'b0; rx_ir = 1'b0; rx_invert = 1'b0;
    advn(2);

    // R9: bypass
    tx_nrz = 1'b0; #1 chk("R9 tx bypass low", tx_ir, 1'b0);
    tx_nrz = 1'b1; #1 chk("R9 tx bypass high", tx_ir, 1'b1);
    rx_ir = 1'b1;  #1 chk("R9 rx bypass high", rx_nrz, 1'b1);
    rx_ir = 1'b0;  #1 chk("R9 rx bypass low", rx_nrz, 1'b0);
    advn(2);
    ir_en = 1'b1;
    #1 chk("R9 coder state cleared rx", rx_nrz, 1'b1);
    advn(4);
    chk("R3 tx dark after re-enable", tx_ir, 1'b0);
    chk("R9 no stale decode", rx_nrz, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule